// File: doc/BRIEF.md
# DTMF Tone Channel Generator

This block produces one tone of a dual-tone dialing pair as a stream of signed digital samples for a later digital-to-analog stage. A two-bit rate code states which of four system clock frequencies is in use: 480 kHz, 960 kHz, 1.92 MHz or 3.84 MHz. A prescaler divides the clock back to one common step rate, so the tone timing is the same for every setting. A group select picks the high or low tone family. A two-bit frequency code picks one of four tones within that family.

Each tone period is split into 16 equal-phase steps of a sine table. When the period is not a multiple of 16, a remainder accumulator spreads the spare step-rate ticks across the steps. Each table value is scaled by one of sixteen gain factors spaced 1 dB apart. The product saturates symmetrically at the signed full scale. Two instances, one with the high group and one with the low group selected, together make a dual-tone generator.

Top module: `dtmf_tone_chan`

## Requirements
- R1: While `rst` is high, `sample_o` is 0 and `sample_vld` is 0. Step counting restarts at step 0 with group high and code 00 latched.
- R2: A `rate_code` of 00, 01, 10 or 11 divides the clock by 1, 2, 4 or 8. One tone period therefore lasts P×2^rate_code clocks, where P is the step-rate period from R3 or R4.
- R3: With `grp_hi`=1, codes 00, 01, 10 and 11 give P = 396, 360, 324 and 294 step-rate ticks. Step k (0..15) lasts floor(P/16) ticks, plus 1 when the 4-bit remainder accumulator (+P mod 16, cleared at step 0) carries. `sample_vld` pulses for one cycle at the start of every step.
- R4: With `grp_hi`=0, codes 00, 01, 10 and 11 give P = 688, 624, 564 and 512 ticks, with the same step rule as R3.
- R5: The sample for step k is based on the table value round(1024·sin(2πk/16)). The sample delivered together with a `sample_vld` pulse belongs to the step that pulse opens.
- R6: A `level_code` c selects gain factor round(476·10^((c−9)/20)) in units of 1/256. Code 1001 is 0 dB, giving a peak of 1904, about 93 % of full scale. The sample is floor(table·factor/256). A level change takes effect on the next clock.
- R7: Results beyond ±2047 saturate to +2047 or −2047. The value −2048 never appears.
- R8: When `tone_en` is low, `sample_o` is 0 from the next clock and `sample_vld` stays 0. The next enable restarts the tone at step 0, so its first sample is 0.
- R9: Changes to `grp_hi` or `freq_code` while enabled take effect only at the next period boundary, after step 15 ends. While disabled, they are taken on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_en | input | 1 | Tone enable; low forces a zero sample and rewinds the phase |
| rate_code | input | 2 | Clock-range code, selects divide by 1, 2, 4 or 8 |
| grp_hi | input | 1 | 1 selects the high tone group, 0 the low group |
| freq_code | input | 2 | Tone select within the group |
| level_code | input | 4 | Output level, −9 dB (0000) to +6 dB (1111) |
| sample_o | output | OUT_W (12) | Signed tone sample |
| sample_vld | output | 1 | One-cycle strobe at the start of each table step |

## Verification
Two events can fall in the same cycle: the period wrap that latches a new tone, and an external change to the tone code. The bench changes `freq_code` a few steps into a period and checks that this period keeps its old length while the next one takes the new length. A second collision is a disable landing in the middle of a step. The bench drops the enable mid-tone and expects a zero sample with no strobe on the very next clock, then a restart from step 0. Throughout, a behavioural model with its own tables, written with integers and reals, is compared with both outputs on every clock.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int IDX_W     = 4;   // 16 table steps per period
  localparam int SINE_W    = 12;
  localparam int GAIN_W    = 10;
  localparam int GAIN_FRAC = 8;
  localparam int CNT_W     = 10;
  localparam int PRE_W     = 3;

  // Step-rate period for each group / code
  function automatic logic [CNT_W-1:0] period_of(input logic hi, input logic [1:0] f);
    logic [CNT_W-1:0] p;
    case ({hi, f})
      3'b100:  p = CNT_W'(396);
      3'b101:  p = CNT_W'(360);
      3'b110:  p = CNT_W'(324);
      3'b111:  p = CNT_W'(294);
      3'b000:  p = CNT_W'(688);
      3'b001:  p = CNT_W'(624);
      3'b010:  p = CNT_W'(564);
      default: p = CNT_W'(512);
    endcase
    return p;
  endfunction

  // Sine value for step k, built from a quarter wave and mirrored
  function automatic logic signed [SINE_W-1:0] sine_at(input logic [IDX_W-1:0] k);
    logic [2:0] q;
    logic [SINE_W-1:0] mag;
    q = (k[2:0] <= 3'd4) ? k[2:0] : 3'(4'd8 - {1'b0, k[2:0]});
    case (q)
      3'd0:    mag = SINE_W'(0);
      3'd1:    mag = SINE_W'(392);
      3'd2:    mag = SINE_W'(724);
      3'd3:    mag = SINE_W'(946);
      default: mag = SINE_W'(1024);
    endcase
    return k[3] ? -$signed(mag) : $signed(mag);
  endfunction

  // Gain factor, 1/256 units, 1 dB apart, code 9 = 0 dB
  function automatic logic [GAIN_W-1:0] gain_of(input logic [3:0] c);
    logic [GAIN_W-1:0] g;
    case (c)
      4'd0:    g = GAIN_W'(169);
      4'd1:    g = GAIN_W'(189);
      4'd2:    g = GAIN_W'(213);
      4'd3:    g = GAIN_W'(239);
      4'd4:    g = GAIN_W'(268);
      4'd5:    g = GAIN_W'(300);
      4'd6:    g = GAIN_W'(337);
      4'd7:    g = GAIN_W'(378);
      4'd8:    g = GAIN_W'(424);
      4'd9:    g = GAIN_W'(476);
      4'd10:   g = GAIN_W'(534);
      4'd11:   g = GAIN_W'(599);
      4'd12:   g = GAIN_W'(672);
      4'd13:   g = GAIN_W'(754);
      4'd14:   g = GAIN_W'(846);
      default: g = GAIN_W'(950);
    endcase
    return g;
  endfunction
endpackage

// File: rtl/dtmf_prescale.sv
module dtmf_prescale
  import dtmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick,
  output logic       phase_zero
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case (rate)
      2'd0:    lim = PRE_W'(0);
      2'd1:    lim = PRE_W'(1);
      2'd2:    lim = PRE_W'(3);
      default: lim = PRE_W'(7);
    endcase
  end

  assign tick       = en && (pre_q >= lim);
  assign phase_zero = (pre_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !en)  pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
    tick |=> phase_zero);  // R2
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> phase_zero);  // R2
endmodule

// File: rtl/dtmf_step_timer.sv
module dtmf_step_timer
  import dtmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             phase_zero,
  input  logic             grp_hi,
  input  logic [1:0]       freq_code,
  output logic [IDX_W-1:0] idx,
  output logic             step_first
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic             hi_q;
  logic [1:0]       f_q;
  logic [CNT_W-1:0] stepc, per, base, len;
  logic [IDX_W-1:0] rem, acc;
  logic [IDX_W:0]   acc_sum;
  logic             last, wrap;

  assign per     = period_of(hi_q, f_q);
  assign base    = per >> IDX_W;
  assign rem     = per[IDX_W-1:0];
  assign acc_sum = {1'b0, acc} + {1'b0, rem};
  assign len     = base + CNT_W'(acc_sum[IDX_W]);
  assign last    = (stepc == len - CNT_W'(1));
  assign wrap    = tick && last && (idx == LAST_IDX);
  assign step_first = en && (stepc == '0) && phase_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepc <= '0; idx <= '0; acc <= '0;
      hi_q  <= 1'b1; f_q <= 2'd0;
    end else if (!en) begin
      stepc <= '0; idx <= '0; acc <= '0;
      hi_q  <= grp_hi; f_q <= freq_code;
    end else if (tick) begin
      if (last) begin
        stepc <= '0;
        idx   <= idx + IDX_W'(1);
        acc   <= wrap ? '0 : acc_sum[IDX_W-1:0];
        if (wrap) begin
          hi_q <= grp_hi;
          f_q  <= freq_code;
        end
      end else begin
        stepc <= stepc + CNT_W'(1);
      end
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    en |-> (stepc < len));  // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && wrap) |=> (idx == '0));  // R3
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> $stable({hi_q, f_q}));  // R9
endmodule

// File: rtl/dtmf_level_scale.sv
module dtmf_level_scale
  import dtmf_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [3:0]              level,
  input  logic                    step_first,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    sample_vld
);
  localparam int PROD_W = SINE_W + GAIN_W + 1;
  localparam int MAXV   = (1 << (OUT_W-1)) - 1;
  localparam logic signed [PROD_W-1:0] P_MAX = PROD_W'(MAXV);
  localparam logic signed [PROD_W-1:0] P_MIN = -P_MAX;

  logic signed [PROD_W-1:0] prod, shifted;
  logic signed [OUT_W-1:0]  sat;

  assign prod    = PROD_W'(sine_at(idx)) * $signed({1'b0, gain_of(level)});
  assign shifted = prod >>> GAIN_FRAC;

  always_comb begin
    if (shifted > P_MAX)      sat = OUT_W'(MAXV);
    else if (shifted < P_MIN) sat = -OUT_W'(MAXV);
    else                      sat = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sample_o   <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_o   <= sat;
      sample_vld <= step_first;
    end
  end

  AST_SYM_CLIP: assert property (@(posedge clk) disable iff (rst)
    sample_o != {1'b1, {(OUT_W-1){1'b0}}});  // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sample_o == '0) && !sample_vld);  // R8
endmodule

// File: rtl/dtmf_tone_chan.sv
module dtmf_tone_chan
  import dtmf_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tone_en,
  input  logic [1:0]              rate_code,
  input  logic                    grp_hi,
  input  logic [1:0]              freq_code,
  input  logic [3:0]              level_code,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    sample_vld
);
  logic             tick, phase_zero, step_first;
  logic [IDX_W-1:0] idx;

  dtmf_prescale u_pre (
    .clk(clk), .rst(rst), .en(tone_en), .rate(rate_code),
    .tick(tick), .phase_zero(phase_zero)
  );

  dtmf_step_timer u_step (
    .clk(clk), .rst(rst), .en(tone_en), .tick(tick), .phase_zero(phase_zero),
    .grp_hi(grp_hi), .freq_code(freq_code), .idx(idx), .step_first(step_first)
  );

  dtmf_level_scale #(.OUT_W(OUT_W)) u_scale (
    .clk(clk), .rst(rst), .en(tone_en), .idx(idx), .level(level_code),
    .step_first(step_first), .sample_o(sample_o), .sample_vld(sample_vld)
  );

  AST_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    sample_vld |-> $past(tone_en));  // R8
endmodule

// File: tb/tb_dtmf_tone_chan.sv
`timescale 1ns/1ps
module tb_dtmf_tone_chan;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, grp_hi = 1'b1;
  logic [1:0] rate = 2'd0, fc = 2'd0;
  logic [3:0] lvl = 4'd9;
  logic signed [11:0] sample;
  logic vld;

  int errors = 0, checks = 0, cyc = 0;
  int m_pre, m_stepc, m_idx, m_acc, m_f, m_sample, m_vld;
  int t_per, t_base, t_rem, t_lim, t_len;
  bit m_hi;

  always #2 clk = ~clk;

  dtmf_tone_chan dut (
    .clk(clk), .rst(rst), .tone_en(en), .rate_code(rate), .grp_hi(grp_hi),
    .freq_code(fc), .level_code(lvl), .sample_o(sample), .sample_vld(vld)
  );

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction
  function automatic int ref_sine(int k);
    return rnd(1024.0 * $sin(2.0 * 3.14159265358979 * k / 16.0));
  endfunction
  function automatic int ref_gain(int c);
    return rnd(476.0 * $pow(10.0, (c - 9) / 20.0));
  endfunction
  function automatic int ref_period(bit hi, int f);
    int hp[4] = '{396, 360, 324, 294};
    int lp[4] = '{688, 624, 564, 512};
    return hi ? hp[f] : lp[f];
  endfunction
  function automatic int scale(int s, int g);
    int p = s * g;
    int q = (p >= 0) ? p / 256 : -((-p + 255) / 256);
    if (q > 2047) q = 2047;
    if (q < -2047) q = -2047;
    return q;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_pre = 0; m_stepc = 0; m_idx = 0; m_acc = 0; m_hi = 1; m_f = 0;
      m_sample = 0; m_vld = 0;
    end else if (!en) begin
      m_pre = 0; m_stepc = 0; m_idx = 0; m_acc = 0; m_hi = grp_hi; m_f = fc;
      m_sample = 0; m_vld = 0;
    end else begin
      t_lim = (1 << rate) - 1;
      t_per = ref_period(m_hi, m_f);
      t_base = t_per / 16; t_rem = t_per % 16;
      m_vld = (m_stepc == 0 && m_pre == 0) ? 1 : 0;
      m_sample = scale(ref_sine(m_idx), ref_gain(lvl));
      t_len = t_base + ((m_acc + t_rem >= 16) ? 1 : 0);
      if (m_pre >= t_lim) begin
        m_pre = 0;
        if (m_stepc == t_len - 1) begin
          m_stepc = 0;
          if (m_idx == 15) begin
            m_idx = 0; m_acc = 0; m_hi = grp_hi; m_f = fc;
          end else begin
            m_idx++; m_acc = (m_acc + t_rem) % 16;
          end
        end else m_stepc++;
      end else m_pre++;
    end
  end

  always @(negedge clk) if (!rst) begin
    chk("R6 model sample", sample, m_sample);
    chk("R3 model strobe", int'(vld), m_vld);
  end

  always @(posedge clk) if (cyc > 190000) begin
    errors++;
    $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wait_vld();
    do @(negedge clk); while (!vld);
  endtask

  task automatic start(bit hi, int f, int r, int l);
    @(negedge clk);
    en = 0; grp_hi = hi; fc = 2'(f); rate = 2'(r); lvl = 4'(l);
    repeat (2) @(negedge clk);
    en = 1;
  endtask

  task automatic period(output int n);
    int t0;
    wait_vld();
    t0 = cyc;
    repeat (16) wait_vld();
    n = cyc - t0;
  endtask

  task automatic peaks(output int mx, output int mn);
    mx = -99999; mn = 99999;
    repeat (16) begin
      wait_vld();
      if (sample > mx) mx = sample;
      if (sample < mn) mn = sample;
    end
  endtask

  initial begin
    int n, mx, mn, g;
    repeat (4) @(negedge clk);
    chk("R1 reset sample", sample, 0);
    chk("R1 reset strobe", int'(vld), 0);
    rst = 0;

    for (int r = 0; r < 4; r++) begin
      start(1, 0, r, 9); period(n);
      chk("R2 divided period", n, 396 * (1 << r));
    end
    for (int f = 0; f < 4; f++) begin
      start(1, f, 0, 9); period(n);
      chk("R3 high group period", n, ref_period(1, f));
    end
    for (int f = 0; f < 4; f++) begin
      start(0, f, 1, 9); period(n);
      chk("R4 low group period", n, 2 * ref_period(0, f));
    end

    // R5: sixteen step samples at 0 dB
    start(1, 3, 0, 9);
    for (int k = 0; k < 16; k++) begin
      wait_vld();
      chk("R5 step sample", sample, scale(ref_sine(k), 476));
    end

    // R6: peaks for several levels
    for (int l = 0; l < 10; l += 4) begin
      start(1, 3, 0, l); peaks(mx, mn);
      g = ref_gain(l);
      chk("R6 positive peak", mx, scale(1024, g));
      chk("R6 negative peak", mn, scale(-1024, g));
    end
    start(1, 3, 0, 9); peaks(mx, mn);
    chk("R6 zero dB peak", mx, 1904);

    // R7: levels above 0 dB clip symmetrically
    start(0, 3, 0, 15); peaks(mx, mn);
    chk("R7 clip high", mx, 2047);
    chk("R7 clip low", mn, -2047);
    start(0, 3, 0, 10); peaks(mx, mn);
    chk("R7 clip one dB", mx, 2047);

    // R8: disable mid step, then restart at phase zero
    start(1, 1, 0, 9);
    repeat (5) wait_vld();
    repeat (3) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R8 disabled sample", sample, 0);
    chk("R8 disabled strobe", int'(vld), 0);
    repeat (20) @(negedge clk);
    chk("R8 still zero", sample, 0);
    en = 1;
    wait_vld();
    chk("R8 restart step 0", sample, 0);
    wait_vld();
    chk("R8 restart step 1", sample, scale(392, 476));

    // R9: code change mid period applies at the boundary
    start(0, 0, 0, 9);
    begin
      int t0;
      wait_vld();
      t0 = cyc;
      repeat (3) wait_vld();
      fc = 2'd3;
      repeat (13) wait_vld();
      chk("R9 old period kept", cyc - t0, 688);
      t0 = cyc;
      repeat (16) wait_vld();
      chk("R9 new period", cyc - t0, 512);
    end

    @(negedge clk);
    en = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule